// File: doc/BRIEF.md
# Optimistic-Send Link with Late Reject and Replay

This block carries flits in one direction across an on-chip network link whose wires are too slow for a request and grant exchange before each transfer. The sending side puts a flit on the link as soon as its local source offers one. It does not check first whether the far queue has room. The receiving side keeps one small queue per virtual channel. A flit that arrives for a full queue is refused, and the refusal is raised on a per-channel reject line in the following cycle.

The sender keeps one replay slot per virtual channel. Each slot holds the flit last launched on that channel until the reject window for that flit has closed. A refused flit goes back onto the link in the cycle after the reject, ahead of any new flit. A channel never has two flits awaiting a verdict at once, so one slot per channel is enough. Two channels can still keep the link busy in every cycle by taking turns.

On the local side the source pushes through a valid, channel-id and data port and is paced by a per-channel ready vector. The sink pops each channel's queue head on its own.

Top module: `spec_link`

## Requirements
- R1: While reset is asserted and right after it, srcReady is all ones, linkValid is 0, linkReject is all zeros and dstValid is all zeros.
- R2: A push (srcValid high with srcReady[srcVc] high) puts that flit on the link in the next cycle: linkValid is 1, linkVc equals srcVc and linkData equals srcData.
- R3: A flit on the link whose channel queue holds fewer than Q_DEPTH entries is enqueued. dstValid[v] is 1 in the next cycle, and bits [v*FLIT_W +: FLIT_W] of dstData show channel v's oldest entry.
- R4: A flit on the link whose channel queue holds Q_DEPTH entries in that cycle is refused, even if the same channel pops in that cycle. In the next cycle, bit v of linkReject (v being the refused flit's channel id) is 1 and every other bit is 0. No reject is raised for a flit that was enqueued.
- R5: In the cycle after a reject, the link carries the refused flit again, with the same linkVc and linkData, in place of any new flit.
- R6: srcReady[v] is 0 while any linkReject bit is 1 or while the link carries channel v, and is 1 otherwise. srcValid with srcReady[srcVc] low has no effect on the link.
- R7: Every pushed flit is delivered exactly once, and in push order within its channel.
- R8: dstPop[v] with dstValid[v] low has no effect: dstValid[v] stays 0 and later flits are delivered in order.
- R9: While one channel's flit is being refused over and over, flits pushed on the other channel are still accepted and delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcValid | input | 1 | Source offers a flit |
| srcVc | input | VC_W | Channel id of the offered flit |
| srcData | input | FLIT_W | Offered flit |
| srcReady | output | VC_N | Per-channel permission to push |
| linkValid | output | 1 | Link carries a flit this cycle |
| linkVc | output | VC_W | Channel id on the link |
| linkData | output | FLIT_W | Flit on the link |
| linkReject | output | VC_N | Per-channel reject for the previous cycle's flit |
| dstPop | input | VC_N | Per-channel pop of the queue head |
| dstValid | output | VC_N | Per-channel queue not empty |
| dstData | output | VC_N*FLIT_W | Queue heads, channel v in bits [v*FLIT_W +: FLIT_W] |

## Verification
The assertions assume the source keeps srcVc below VC_N. They also assume srcReady is read in the same cycle as the push, so a push is taken to happen only when srcValid meets a high srcReady[srcVc]. The stimulus draws channel ids only from the valid range. The stimulus sometimes raises srcValid while srcReady is low, and sometimes pops empty queues. These inputs are legal and must be ignored. The per-channel pop rates change in stages so that the queues often sit full and the reject-and-replay loop runs for long stretches.

// File: rtl/spec_link_pkg.sv
package spec_link_pkg;
  localparam int VC_N    = 2;
  localparam int FLIT_W  = 16;
  localparam int Q_DEPTH = 2;
  localparam int VC_W    = (VC_N > 1) ? $clog2(VC_N) : 1;
  localparam int PTR_W   = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam int CNT_W   = $clog2(Q_DEPTH + 1);

  // Strobes from the control to the datapath
  typedef struct packed {
    logic                        linkLoad;
    logic                        linkFromReplay;
    logic [VC_W-1:0]             linkVcNext;
    logic [VC_N-1:0]             slotWrite;
    logic [VC_N-1:0]             qPush;
    logic [VC_N-1:0][PTR_W-1:0]  qWrIdx;
    logic [VC_N-1:0][PTR_W-1:0]  qRdIdx;
  } strobe_t;
endpackage

// File: rtl/spec_link_ctrl.sv
module spec_link_ctrl
  import spec_link_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            srcValid,
  input  logic [VC_W-1:0] srcVc,
  output logic [VC_N-1:0] srcReady,
  input  logic [VC_N-1:0] dstPop,
  output logic [VC_N-1:0] dstValid,
  output logic            linkValid,
  output logic [VC_W-1:0] linkVc,
  output logic [VC_N-1:0] linkReject,
  output strobe_t         strb
);
  logic            linkValidQ;
  logic [VC_W-1:0] linkVcQ;
  logic [VC_N-1:0] rejQ;

  logic [VC_N-1:0] inFlight, qFull, qTake, rejNext, qPop;
  logic            replayHit, newSend;
  logic [VC_W-1:0] replayVc;

  logic [CNT_W-1:0] cnt   [VC_N];
  logic [PTR_W-1:0] wrPtr [VC_N];
  logic [PTR_W-1:0] rdPtr [VC_N];

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(Q_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // R5: a pending reject owns the next link slot
  always_comb begin
    replayHit = |rejQ;
    replayVc  = '0;
    for (int v = 0; v < VC_N; v++) begin
      if (rejQ[v]) replayVc = VC_W'(v);
    end
  end

  // R6: a channel may launch only when its replay slot is free
  always_comb begin
    newSend = 1'b0;
    for (int v = 0; v < VC_N; v++) begin
      inFlight[v] = linkValidQ && (linkVcQ == VC_W'(v));
      srcReady[v] = !replayHit && !inFlight[v];
      if (srcValid && (srcVc == VC_W'(v)) && srcReady[v]) newSend = 1'b1;
    end
  end

  // R4: verdict taken on the occupancy seen at arrival; R8: pop gated by occupancy
  always_comb begin
    for (int v = 0; v < VC_N; v++) begin
      qFull[v]   = (cnt[v] == CNT_W'(Q_DEPTH));
      qTake[v]   = inFlight[v] && !qFull[v];
      rejNext[v] = inFlight[v] && qFull[v];
      qPop[v]    = dstPop[v] && (cnt[v] != '0);
      dstValid[v] = (cnt[v] != '0);
    end
  end

  always_comb begin
    strb                = '0;
    strb.linkLoad       = replayHit || newSend;
    strb.linkFromReplay = replayHit;
    strb.linkVcNext     = replayHit ? replayVc : srcVc;
    strb.qPush          = qTake;
    for (int v = 0; v < VC_N; v++) begin
      strb.slotWrite[v] = newSend && (srcVc == VC_W'(v));
      strb.qWrIdx[v]    = wrPtr[v];
      strb.qRdIdx[v]    = rdPtr[v];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkValidQ <= 1'b0;
      linkVcQ    <= '0;
      rejQ       <= '0;
    end else begin
      linkValidQ <= strb.linkLoad;
      linkVcQ    <= strb.linkVcNext;
      rejQ       <= rejNext;
    end
  end

  for (genvar v = 0; v < VC_N; v++) begin : g_occ
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[v]   <= '0;
        wrPtr[v] <= '0;
        rdPtr[v] <= '0;
      end else begin
        if (qTake[v]) wrPtr[v] <= bumpPtr(wrPtr[v]);
        if (qPop[v])  rdPtr[v] <= bumpPtr(rdPtr[v]);
        case ({qTake[v], qPop[v]})
          2'b10:   cnt[v] <= cnt[v] + CNT_W'(1);
          2'b01:   cnt[v] <= cnt[v] - CNT_W'(1);
          default: cnt[v] <= cnt[v];
        endcase
      end
    end
  end

  assign linkValid  = linkValidQ;
  assign linkVc     = linkVcQ;
  assign linkReject = rejQ;
endmodule

// File: rtl/spec_link_dp.sv
module spec_link_dp
  import spec_link_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [FLIT_W-1:0]      srcData,
  output logic [FLIT_W-1:0]      linkData,
  output logic [VC_N*FLIT_W-1:0] dstData
);
  logic [FLIT_W-1:0] slot [VC_N];
  logic [FLIT_W-1:0] linkDataQ;

  // Replay slots: one flit per channel awaiting its verdict
  for (genvar v = 0; v < VC_N; v++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 slot[v] <= '0;
      else if (strb.slotWrite[v]) slot[v] <= srcData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             linkDataQ <= '0;
    else if (strb.linkLoad) linkDataQ <= strb.linkFromReplay ? slot[strb.linkVcNext] : srcData;
  end

  // R3: per-channel receive queues
  for (genvar v = 0; v < VC_N; v++) begin : g_queue
    logic [FLIT_W-1:0] qMem [Q_DEPTH];
    always_ff @(posedge clk) begin
      if (strb.qPush[v]) qMem[strb.qWrIdx[v]] <= linkDataQ;
    end
    assign dstData[v*FLIT_W +: FLIT_W] = qMem[strb.qRdIdx[v]];
  end

  assign linkData = linkDataQ;
endmodule

// File: rtl/spec_link.sv
module spec_link
  import spec_link_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   srcValid,
  input  logic [VC_W-1:0]        srcVc,
  input  logic [FLIT_W-1:0]      srcData,
  output logic [VC_N-1:0]        srcReady,
  output logic                   linkValid,
  output logic [VC_W-1:0]        linkVc,
  output logic [FLIT_W-1:0]      linkData,
  output logic [VC_N-1:0]        linkReject,
  input  logic [VC_N-1:0]        dstPop,
  output logic [VC_N-1:0]        dstValid,
  output logic [VC_N*FLIT_W-1:0] dstData
);
  strobe_t strb;

  spec_link_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .srcValid   (srcValid),
    .srcVc      (srcVc),
    .srcReady   (srcReady),
    .dstPop     (dstPop),
    .dstValid   (dstValid),
    .linkValid  (linkValid),
    .linkVc     (linkVc),
    .linkReject (linkReject),
    .strb       (strb)
  );

  spec_link_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .srcData  (srcData),
    .linkData (linkData),
    .dstData  (dstData)
  );
endmodule

// File: rtl/spec_link_chk.sv
module spec_link_chk
  import spec_link_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   srcValid,
  input logic [VC_W-1:0]        srcVc,
  input logic [FLIT_W-1:0]      srcData,
  input logic [VC_N-1:0]        srcReady,
  input logic                   linkValid,
  input logic [VC_W-1:0]        linkVc,
  input logic [FLIT_W-1:0]      linkData,
  input logic [VC_N-1:0]        linkReject,
  input logic [VC_N-1:0]        dstPop,
  input logic [VC_N-1:0]        dstValid,
  input logic [VC_N*FLIT_W-1:0] dstData
);
  a_r2_push_reaches_link: assert property (@(posedge clk) disable iff (!rstN)
    (srcValid && srcReady[srcVc]) |=> (linkValid && linkVc == $past(srcVc) && linkData == $past(srcData)));

  a_r4_reject_single: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(linkReject));

  a_r4_reject_follows_arrival: assert property (@(posedge clk) disable iff (!rstN)
    (linkReject != '0) |-> ($past(linkValid) && linkReject == (VC_N'(1) << $past(linkVc))));

  a_r5_replay_next: assert property (@(posedge clk) disable iff (!rstN)
    (linkReject != '0) |=> (linkValid && linkVc == $past(linkVc, 2) && linkData == $past(linkData, 2)));

  a_r6_ready_during_reject: assert property (@(posedge clk) disable iff (!rstN)
    (linkReject != '0) |-> (srcReady == '0));

  a_r6_ready_busy_vc: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> !srcReady[linkVc]);

  for (genvar v = 0; v < VC_N; v++) begin : g_vc
    a_r3_fill_from_link: assert property (@(posedge clk) disable iff (!rstN)
      $rose(dstValid[v]) |-> ($past(linkValid) && $past(linkVc) == VC_W'(v)));
  end
endmodule

bind spec_link spec_link_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .srcValid   (srcValid),
  .srcVc      (srcVc),
  .srcData    (srcData),
  .srcReady   (srcReady),
  .linkValid  (linkValid),
  .linkVc     (linkVc),
  .linkData   (linkData),
  .linkReject (linkReject),
  .dstPop     (dstPop),
  .dstValid   (dstValid),
  .dstData    (dstData)
);

// File: tb/test_spec_link.sv
`timescale 1ns/1ps
module test_spec_link;
  import spec_link_pkg::*;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic                   srcValid;
  logic [VC_W-1:0]        srcVc;
  logic [FLIT_W-1:0]      srcData;
  logic [VC_N-1:0]        srcReady;
  logic                   linkValid;
  logic [VC_W-1:0]        linkVc;
  logic [FLIT_W-1:0]      linkData;
  logic [VC_N-1:0]        linkReject;
  logic [VC_N-1:0]        dstPop;
  logic [VC_N-1:0]        dstValid;
  logic [VC_N*FLIT_W-1:0] dstData;

  always #2 clk = ~clk;

  spec_link i_spec_link (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcVc(srcVc), .srcData(srcData),
    .srcReady(srcReady), .linkValid(linkValid), .linkVc(linkVc), .linkData(linkData),
    .linkReject(linkReject), .dstPop(dstPop), .dstValid(dstValid), .dstData(dstData)
  );

  int checks = 0;
  int fails  = 0;
  int rejSeen = 0;

  // Reference state for the current cycle
  int                mCnt  [VC_N];
  logic [FLIT_W-1:0] mQ    [VC_N][Q_DEPTH];
  bit                mLinkValid;
  int                mLinkVc;
  logic [FLIT_W-1:0] mLinkData;
  bit                mLinkReplay;
  logic [VC_N-1:0]   mRej;
  int                mPrevVc;
  logic [FLIT_W-1:0] mPrevData;
  int                seqPush [VC_N];
  int                seqPop  [VC_N];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [FLIT_W-1:0] mkFlit(input int v, input int s);
    logic [FLIT_W-1:0] f;
    f = FLIT_W'(s);
    f[FLIT_W-1 -: VC_W] = VC_W'(v);
    return f;
  endfunction

  function automatic bit expReady(input int v);
    return !(|mRej) && !(mLinkValid && mLinkVc == v);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // One cycle: compare at the negedge, drive inputs, advance the reference
  task automatic step(input bit wantPush, input int pv, input logic [VC_N-1:0] popReq);
    bit doPush;
    logic [VC_N-1:0] newRej;
    bit arrFull;
    chk(linkValid == mLinkValid, mLinkReplay ? "R5 linkValid" : "R2 linkValid", linkValid, mLinkValid);
    if (mLinkValid) begin
      chk(linkVc == VC_W'(mLinkVc), mLinkReplay ? "R5 linkVc" : "R2 linkVc", linkVc, mLinkVc);
      chk(linkData == mLinkData, mLinkReplay ? "R5 linkData" : "R2 linkData", linkData, mLinkData);
    end
    chk(linkReject == mRej, "R4 linkReject", linkReject, mRej);
    if (linkReject != '0) rejSeen++;
    for (int v = 0; v < VC_N; v++) begin
      chk(srcReady[v] == expReady(v), "R6 srcReady", srcReady[v], expReady(v));
      chk(dstValid[v] == (mCnt[v] > 0), "R3/R8 dstValid", dstValid[v], mCnt[v] > 0);
      if (mCnt[v] > 0)
        chk(dstData[v*FLIT_W +: FLIT_W] == mQ[v][0], "R3 dstData", dstData[v*FLIT_W +: FLIT_W], mQ[v][0]);
    end

    doPush   = wantPush && expReady(pv);
    srcValid = wantPush;
    srcVc    = VC_W'(pv);
    srcData  = mkFlit(pv, seqPush[pv]);
    dstPop   = popReq;

    for (int v = 0; v < VC_N; v++) begin
      newRej[v] = 1'b0;
      arrFull = (mCnt[v] == Q_DEPTH);
      if (mLinkValid && mLinkVc == v && arrFull) newRej[v] = 1'b1;
      if (popReq[v] && mCnt[v] > 0) begin
        chk(dstData[v*FLIT_W +: FLIT_W] == mkFlit(v, seqPop[v]), "R7 delivery order",
            dstData[v*FLIT_W +: FLIT_W], mkFlit(v, seqPop[v]));
        seqPop[v]++;
        for (int i = 0; i < Q_DEPTH - 1; i++) mQ[v][i] = mQ[v][i+1];
        mCnt[v]--;
      end
      if (mLinkValid && mLinkVc == v && !arrFull) begin
        mQ[v][mCnt[v]] = mLinkData;
        mCnt[v]++;
      end
    end

    if (|mRej) begin
      mPrevVc = mLinkVc; mPrevData = mLinkData;
      mLinkVc = mPrevVcReplay(); mLinkData = replayData;
      mLinkValid = 1'b1; mLinkReplay = 1'b1;
    end else begin
      mPrevVc = mLinkVc; mPrevData = mLinkData;
      mLinkReplay = 1'b0;
      mLinkValid  = doPush;
      if (doPush) begin
        mLinkVc   = pv;
        mLinkData = mkFlit(pv, seqPush[pv]);
        seqPush[pv]++;
      end
    end
    replayVcHold = mPrevVc;
    replayData   = mPrevData;
    mRej = newRej;
    @(negedge clk);
  endtask

  // Flit that was on the link in the previous cycle (target of a reject)
  int                replayVcHold;
  logic [FLIT_W-1:0] replayData;
  function automatic int mPrevVcReplay();
    return replayVcHold;
  endfunction

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; srcValid = 1'b0; srcVc = '0; srcData = '0; dstPop = '0;
    for (int v = 0; v < VC_N; v++) begin
      mCnt[v] = 0; seqPush[v] = 0; seqPop[v] = 0;
    end
    mLinkValid = 0; mLinkVc = 0; mLinkData = '0; mLinkReplay = 0; mRej = '0;
    mPrevVc = 0; mPrevData = '0; replayVcHold = 0; replayData = '0;
    repeat (3) @(negedge clk);
    chk(srcReady == '1, "R1 srcReady", srcReady, '1);
    chk(linkValid == 1'b0, "R1 linkValid", linkValid, 0);
    chk(linkReject == '0, "R1 linkReject", linkReject, 0);
    chk(dstValid == '0, "R1 dstValid", dstValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4/R5/R9: keep channel 0 pushing without pops, fill gaps with channel 1
    for (int c = 0; c < 24; c++) step(1'b1, expReady(0) ? 0 : 1, '0);
    chk(rejSeen > 0, "R4 reject observed", rejSeen, 1);
    chk(dstValid[1] == 1'b1, "R9 other channel delivered", dstValid[1], 1);
    chk(seqPush[1] >= Q_DEPTH, "R9 other channel accepted", seqPush[1], Q_DEPTH);

    // Drain, then pop on empty queues (R8)
    for (int c = 0; c < 16; c++) step(1'b0, 0, '1);
    for (int c = 0; c < 6; c++) step(1'b0, 0, '1);
    chk(dstValid == '0, "R8 empty after idle pops", dstValid, 0);
    step(1'b1, 1, '1);
    for (int c = 0; c < 4; c++) step(1'b0, 0, '0);
    chk(dstValid[1] == 1'b1, "R8 later flit delivered", dstValid[1], 1);

    // Random traffic with staged pop rates
    for (int blk = 0; blk < 8; blk++) begin
      int rate0 = 15 + 10 * blk;
      int rate1 = 95 - 10 * blk;
      for (int c = 0; c < 500; c++) begin
        logic [VC_N-1:0] pops;
        pops = '0;
        pops[0] = ($urandom_range(0, 99) < rate0);
        if (VC_N > 1) pops[1] = ($urandom_range(0, 99) < rate1);
        step($urandom_range(0, 99) < 70, $urandom_range(0, VC_N - 1), pops);
      end
    end

    for (int c = 0; c < 24; c++) step(1'b0, 0, '1);
    for (int v = 0; v < VC_N; v++)
      chk(seqPop[v] == seqPush[v], "R7 exactly once", seqPop[v], seqPush[v]);

    summary();
    $finish;
  end
endmodule